// File: doc/BRIEF.md
# Three-Multiplier Complex Product Pipeline

This block forms the product of two complex numbers, x = x_re + j·x_im and y = y_re + j·y_im, and needs only three real multiplications per result instead of four. It first forms a cross term, K = (x_re − x_im)·y_im, and uses it in both outputs. The real part is then (y_re − y_im)·x_re + K and the imaginary part is (y_re + y_im)·x_im + K. Pre-adders come before the multipliers and post-adders come after them. Every stage has its own register, so a new operand set can enter on every clock.

Operands arrive on a valid/ready stream and results leave on a second valid/ready stream. An input beat transfers on a clock edge where `in_vld` and `in_rdy` are both high. An output beat transfers on an edge where `out_vld` and `out_rdy` are both high. When the consumer holds `out_rdy` low while a result is waiting, the whole pipeline freezes and `in_rdy` drops. No beat is lost or repeated, so a producer must hold its operands until they are accepted. Results are full precision with no rounding or truncation. A synchronous reset clears only the record of which stages hold valid data.

Top module: `cmul3_top`

## Requirements
- R1: `out_re` equals x_re·y_re − x_im·y_im of the matching input beat, exact as a 34-bit two's-complement value.
- R2: `out_im` equals x_re·y_im + x_im·y_re of the matching input beat, exact as a 34-bit two's-complement value.
- R3: With `out_rdy` held high, a beat accepted on clock edge n shows `out_vld` high after edge n+3. Counted from the cycle in which the beat is presented, this is a latency of four cycles.
- R4: With `out_rdy` held high, `in_rdy` stays high and back-to-back input beats give one result per cycle, in input order.
- R5: Operands at the 16-bit extremes (−32768 and 32767, in any combination) give exact results with no wrap, including the imaginary value 2^31.
- R6: While `out_vld` is high and `out_rdy` is low, `in_rdy` is low, and on the next cycle `out_vld`, `out_re` and `out_im` are unchanged.
- R7: After a cycle with `rst` high, `out_vld` is low, and beats that were in flight at the reset edge never appear.
- R8: Cycles where `in_vld` is low create no output beat. The number of output beats equals the number of accepted input beats.
- R9: Operands are taken only on an edge where `in_vld` and `in_rdy` are both high. Values driven at any other time never reach an output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears the valid pipeline |
| in_vld | input | 1 | Input beat valid |
| in_rdy | output | 1 | Block can accept an input beat |
| x_re | input | 16 | Real part of x, signed |
| x_im | input | 16 | Imaginary part of x, signed |
| y_re | input | 16 | Real part of y, signed |
| y_im | input | 16 | Imaginary part of y, signed |
| out_vld | output | 1 | Result beat valid |
| out_rdy | input | 1 | Consumer accepts the result beat |
| out_re | output | 34 | Real part of the product, signed |
| out_im | output | 34 | Imaginary part of the product, signed |

## Verification
The hardest state to reach from the ports is a stall that lands while the pipeline holds a mix of valid beats and bubbles. In that state the frozen output must hold and the operands presented during the stall must not be taken. The bench drives a long pseudo-random stream in which `in_vld` and `out_rdy` toggle independently, so stalls fall at every fill pattern of the four stages. While `in_vld` is low it drives junk operands. The bench then checks each held output and each popped result against its own arithmetic. Before that stream, a sweep of all 4096 combinations of eight edge-heavy operand values at full rate covers the wrap-prone extremes.

// File: rtl/cmul3_pkg.sv
package cmul3_pkg;
  localparam int unsigned CM_NPROD = 3;
  typedef enum logic [1:0] {
    PR_RE = 2'd0,
    PR_IM = 2'd1,
    PR_SH = 2'd2
  } prod_sel_e;
endpackage

// File: rtl/cmul3_preadd.sv
module cmul3_preadd #(
  parameter int IN_W  = 16,
  parameter int PRE_W = IN_W + 1
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic signed [IN_W-1:0]  xr,
  input  logic signed [IN_W-1:0]  xi,
  input  logic signed [IN_W-1:0]  yr,
  input  logic signed [IN_W-1:0]  yi,
  output logic signed [PRE_W-1:0] x_diff,
  output logic signed [PRE_W-1:0] y_diff,
  output logic signed [PRE_W-1:0] y_sum,
  output logic signed [IN_W-1:0]  xr_q,
  output logic signed [IN_W-1:0]  xi_q,
  output logic signed [IN_W-1:0]  yi_q
);
  logic signed [PRE_W-1:0] xr_w, xi_w, yr_w, yi_w;

  always_comb begin
    xr_w = {{(PRE_W-IN_W){xr[IN_W-1]}}, xr};
    xi_w = {{(PRE_W-IN_W){xi[IN_W-1]}}, xi};
    yr_w = {{(PRE_W-IN_W){yr[IN_W-1]}}, yr};
    yi_w = {{(PRE_W-IN_W){yi[IN_W-1]}}, yi};
  end

  always_ff @(posedge clk) begin
    if (en) begin
      x_diff <= xr_w - xi_w;
      y_diff <= yr_w - yi_w;
      y_sum  <= yr_w + yi_w;
      xr_q   <= xr;
      xi_q   <= xi;
      yi_q   <= yi;
    end
  end
endmodule

// File: rtl/cmul3_mult.sv
module cmul3_mult #(
  parameter int X_W  = 17,
  parameter int Y_W  = 16,
  parameter int XP_W = 27,
  parameter int YP_W = 18,
  parameter int P_W  = 48
) (
  input  logic                  clk,
  input  logic                  en,
  input  logic signed [X_W-1:0] x,
  input  logic signed [Y_W-1:0] y,
  output logic signed [P_W-1:0] p
);
  localparam int M_W = XP_W + YP_W;

  logic signed [XP_W-1:0] xp;
  logic signed [YP_W-1:0] yp;
  logic signed [M_W-1:0]  m;

  always_comb begin
    xp = {{(XP_W-X_W){x[X_W-1]}}, x};
    yp = {{(YP_W-Y_W){y[Y_W-1]}}, y};
    m  = xp * yp;
  end

  always_ff @(posedge clk) begin
    if (en) p <= {{(P_W-M_W){m[M_W-1]}}, m};
  end
endmodule

// File: rtl/cmul3_postadd.sv
module cmul3_postadd #(
  parameter int P_W = 48
) (
  input  logic                  clk,
  input  logic                  en,
  input  logic signed [P_W-1:0] p_re,
  input  logic signed [P_W-1:0] p_im,
  input  logic signed [P_W-1:0] p_sh,
  output logic signed [P_W-1:0] s_re,
  output logic signed [P_W-1:0] s_im
);
  always_ff @(posedge clk) begin
    if (en) begin
      s_re <= p_re + p_sh;
      s_im <= p_im + p_sh;
    end
  end
endmodule

// File: rtl/cmul3_top.sv
module cmul3_top
  import cmul3_pkg::*;
#(
  parameter int IN_W    = 16,
  parameter int XPORT_W = 27,
  parameter int YPORT_W = 18,
  parameter int ACC_W   = 48
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_vld,
  output logic                      in_rdy,
  input  logic signed [IN_W-1:0]    x_re,
  input  logic signed [IN_W-1:0]    x_im,
  input  logic signed [IN_W-1:0]    y_re,
  input  logic signed [IN_W-1:0]    y_im,
  output logic                      out_vld,
  input  logic                      out_rdy,
  output logic signed [2*IN_W+1:0]  out_re,
  output logic signed [2*IN_W+1:0]  out_im
);
  localparam int PRE_W = IN_W + 1;
  localparam int OUT_W = 2*IN_W + 2;
  localparam int LAT   = 4;

  logic           adv;
  logic [LAT-1:0] vld;

  assign adv     = !out_vld || out_rdy;
  assign in_rdy  = adv;
  assign out_vld = vld[LAT-1];

  // valid pipeline, the only reset state
  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (adv) vld <= {vld[LAT-2:0], in_vld};
  end

  // stage 0: operand capture
  logic signed [IN_W-1:0] xr0, xi0, yr0, yi0;
  always_ff @(posedge clk) begin
    if (adv) begin
      xr0 <= x_re;
      xi0 <= x_im;
      yr0 <= y_re;
      yi0 <= y_im;
    end
  end

  // stage 1: pre-adders
  logic signed [PRE_W-1:0] pre_xd, pre_yd, pre_ys;
  logic signed [IN_W-1:0]  xr1, xi1, yi1;

  cmul3_preadd #(.IN_W(IN_W), .PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .en    (adv),
    .xr    (xr0),
    .xi    (xi0),
    .yr    (yr0),
    .yi    (yi0),
    .x_diff(pre_xd),
    .y_diff(pre_yd),
    .y_sum (pre_ys),
    .xr_q  (xr1),
    .xi_q  (xi1),
    .yi_q  (yi1)
  );

  // stage 2: three multipliers
  logic signed [PRE_W-1:0] mx [CM_NPROD];
  logic signed [IN_W-1:0]  my [CM_NPROD];
  logic signed [ACC_W-1:0] mp [CM_NPROD];

  always_comb begin
    mx[PR_RE] = pre_yd;  my[PR_RE] = xr1;
    mx[PR_IM] = pre_ys;  my[PR_IM] = xi1;
    mx[PR_SH] = pre_xd;  my[PR_SH] = yi1;
  end

  for (genvar g = 0; g < CM_NPROD; g++) begin : g_mul
    cmul3_mult #(
      .X_W (PRE_W),
      .Y_W (IN_W),
      .XP_W(XPORT_W),
      .YP_W(YPORT_W),
      .P_W (ACC_W)
    ) u_mul (
      .clk(clk),
      .en (adv),
      .x  (mx[g]),
      .y  (my[g]),
      .p  (mp[g])
    );
  end

  // stage 3: post-adders
  logic signed [ACC_W-1:0] sum_re, sum_im;

  cmul3_postadd #(.P_W(ACC_W)) u_post (
    .clk (clk),
    .en  (adv),
    .p_re(mp[PR_RE]),
    .p_im(mp[PR_IM]),
    .p_sh(mp[PR_SH]),
    .s_re(sum_re),
    .s_im(sum_im)
  );

  assign out_re = sum_re[OUT_W-1:0];
  assign out_im = sum_im[OUT_W-1:0];

  // R1
  re_sign_chk: assert property (@(posedge clk) disable iff (rst)
    vld[1] && adv |=> (mp[PR_RE] == '0) ||
      (mp[PR_RE][ACC_W-1] == ($past(pre_yd[PRE_W-1]) ^ $past(xr1[IN_W-1]))));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> ((sum_re[ACC_W-1:OUT_W-1] == '0) || (sum_re[ACC_W-1:OUT_W-1] == '1)) &&
                ((sum_im[ACC_W-1:OUT_W-1] == '0) || (sum_im[ACC_W-1:OUT_W-1] == '1)));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld && !out_rdy |=> out_vld && $stable(out_re) && $stable(out_im));

  // R7
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_vld);
endmodule

// File: tb/tb_cmul3_top.sv
module tb_cmul3_top;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W  = 16;
  localparam int OUT_W = 2*IN_W + 2;
  localparam int QD    = 16384;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0, in_rdy, out_vld, out_rdy = 1'b1;
  logic signed [IN_W-1:0]  x_re = '0, x_im = '0, y_re = '0, y_im = '0;
  logic signed [OUT_W-1:0] out_re, out_im;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmul3_top dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_rdy(in_rdy),
    .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im),
    .out_vld(out_vld), .out_rdy(out_rdy), .out_re(out_re), .out_im(out_im)
  );

  int total = 0, bad = 0, cyc = 0, wp = 0, rp = 0, nout = 0;
  longint exp_re [QD];
  longint exp_im [QD];
  int     exp_cy [QD];
  bit     exp_ex [QD];
  bit     lat_on = 1'b0;
  bit     held = 1'b0;
  longint held_re, held_im;
  int unsigned seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic logic signed [IN_W-1:0] pick(input int i);
    case (i)
      0: pick = -16'sd32768;
      1: pick = -16'sd32767;
      2: pick = -16'sd12345;
      3: pick = -16'sd1;
      4: pick = 16'sd0;
      5: pick = 16'sd1;
      6: pick = 16'sd23456;
      default: pick = 16'sd32767;
    endcase
  endfunction

  function automatic int unsigned nxt();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // one cycle: drive at negedge, judge both handshakes, move to next negedge
  task automatic step(input bit v, input logic signed [IN_W-1:0] a, b, c, d,
                      input bit rdy, output bit took);
    in_vld = v; x_re = a; x_im = b; y_re = c; y_im = d; out_rdy = rdy;
    #1;
    if (held) begin
      // R6: frozen output beat
      chk(out_vld === 1'b1, "R6 hold valid", longint'(out_vld), 1);
      chk(longint'(out_re) == held_re, "R6 hold re", longint'(out_re), held_re);
      chk(longint'(out_im) == held_im, "R6 hold im", longint'(out_im), held_im);
      held = 1'b0;
    end
    took = v && in_rdy;
    if (took) begin
      exp_re[wp % QD] = longint'(a) * longint'(c) - longint'(b) * longint'(d);
      exp_im[wp % QD] = longint'(a) * longint'(d) + longint'(b) * longint'(c);
      exp_cy[wp % QD] = cyc;
      exp_ex[wp % QD] = (a == -16'sd32768) || (b == -16'sd32768) || (c == -16'sd32768) ||
                        (d == -16'sd32768) || (a == 16'sd32767) || (d == 16'sd32767);
      wp++;
    end
    if (out_vld && !rdy) begin
      chk(in_rdy == 1'b0, "R6 in_rdy low in stall", longint'(in_rdy), 0);
      held = 1'b1; held_re = longint'(out_re); held_im = longint'(out_im);
    end
    if (out_vld && rdy) begin
      nout++;
      if (rp == wp) begin
        chk(1'b0, "R8 spurious output beat", 1, 0);
      end else begin
        chk(longint'(out_re) == exp_re[rp % QD], exp_ex[rp % QD] ? "R5 real" : "R1",
            longint'(out_re), exp_re[rp % QD]);
        chk(longint'(out_im) == exp_im[rp % QD], exp_ex[rp % QD] ? "R5 imag" : "R2",
            longint'(out_im), exp_im[rp % QD]);
        if (lat_on)
          chk(cyc - exp_cy[rp % QD] == 4, "R3 latency", cyc - exp_cy[rp % QD], 4);
        rp++;
      end
    end
    @(negedge clk);
    cyc++;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit tk;
    int seen;
    logic signed [IN_W-1:0] ha, hb, hc, hd;
    bit pend;
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(1'b0, '0, '0, '0, '0, 1'b1, tk);
    rst = 1'b0;
    #1;
    // R7: reset state
    chk(out_vld == 1'b0, "R7 reset out_vld", longint'(out_vld), 0);
    chk(in_rdy == 1'b1, "R4 ready after reset", longint'(in_rdy), 1);

    // single beat, latency
    lat_on = 1'b1;
    step(1'b1, 16'sd3, -16'sd4, 16'sd5, 16'sd7, 1'b1, tk);
    seen = nout;
    for (int i = 0; i < 8; i++) step(1'b0, 16'sd99, 16'sd99, 16'sd99, 16'sd99, 1'b1, tk);
    chk(nout - seen == 1, "R3 single beat count", nout - seen, 1);
    chk(rp == wp, "R8 drained", rp, wp);

    // full-rate sweep over edge-heavy operand values
    seen = nout;
    for (int i0 = 0; i0 < 8; i0++)
      for (int i1 = 0; i1 < 8; i1++)
        for (int i2 = 0; i2 < 8; i2++)
          for (int i3 = 0; i3 < 8; i3++) begin
            step(1'b1, pick(i0), pick(i1), pick(i2), pick(i3), 1'b1, tk);
            if (!tk) chk(1'b0, "R4 in_rdy dropped at full rate", 0, 1);
          end
    for (int i = 0; i < 6; i++) step(1'b0, '0, '0, '0, '0, 1'b1, tk);
    chk(nout - seen == 4096, "R4 sweep beat count", nout - seen, 4096);
    chk(rp == wp, "R4 sweep drained", rp, wp);
    lat_on = 1'b0;

    // random valid gaps and back-pressure; junk data while idle
    pend = 1'b0; ha = '0; hb = '0; hc = '0; hd = '0;
    for (int i = 0; i < 3000; i++) begin
      bit v, r;
      r = (nxt() % 10) < 6;
      if (pend) v = 1'b1;
      else begin
        v  = (nxt() % 10) < 7;
        ha = IN_W'(nxt()); hb = IN_W'(nxt()); hc = IN_W'(nxt()); hd = IN_W'(nxt());
      end
      if (v) step(1'b1, ha, hb, hc, hd, r, tk);
      else   step(1'b0, IN_W'(nxt()), IN_W'(nxt()), IN_W'(nxt()), IN_W'(nxt()), r, tk);
      pend = v && !tk;
    end
    for (int i = 0; i < 10; i++) step(1'b0, 16'sd77, 16'sd77, 16'sd77, 16'sd77, 1'b1, tk);
    chk(rp == wp, "R9 accepted equals delivered", rp, wp);
    chk(out_vld == 1'b0, "R8 idle no valid", longint'(out_vld), 0);

    // reset with beats in flight
    for (int i = 0; i < 3; i++) step(1'b1, 16'sd100, 16'sd200, 16'sd300, 16'sd400, 1'b1, tk);
    rst = 1'b1;
    step(1'b0, '0, '0, '0, '0, 1'b1, tk);
    rst = 1'b0;
    rp = wp;
    seen = nout;
    for (int i = 0; i < 6; i++) begin
      #1;
      chk(out_vld == 1'b0, "R7 flushed beat", longint'(out_vld), 0);
      step(1'b0, '0, '0, '0, '0, 1'b1, tk);
    end
    chk(nout == seen, "R7 no beat after reset", nout - seen, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule